// File: doc/BRIEF.md
# NRZ Receive Deserializer Channel

This block takes one continuous NRZ serial stream, whose bit clock is supplied from outside by a line interface, and turns it into bytes for a host running on an unrelated system clock. The nominal line rate is 2.048 MHz, one data bit per bit-clock cycle, which gives a completed byte every 3.9 us (256 kHz). Each channel has its own bit clock, so several instances can sit side by side with no shared timing.

In the bit-clock domain, a shift register collects eight bits. When the eighth bit arrives, the whole byte is copied into a holding register and an event toggle flips. The toggle crosses into the system domain through a two-flop synchronizer. An edge detector turns it back into a one-cycle byte event. On that event the held byte is captured into the output register and a ready flag is raised, which is suitable as an interrupt. A read strobe clears the ready flag. If a byte arrives while the previous one is still unread, a sticky overrun flag is set, and only a separate clear strobe removes it.

Top module: `nrz_rx_chan`

## Requirements
- R1: While `rst_n` is low, `rx_ready` and `rx_ovr` are 0 and `rx_data` is 8'h00.
- R2: Bits are sampled on the rising edge of `bit_clk`, most significant bit first. Every eighth sampled bit completes a byte, and that byte appears on `rx_data`. `rx_data` does not change except when a byte completes.
- R3: `rx_ready` rises at the third rising edge of `clk` after the `bit_clk` rising edge that samples a byte's eighth bit. This assumes that `bit_clk` edge does not coincide with a `clk` edge.
- R4: `rx_ready` only rises in response to a completed byte, and each byte produces exactly one event.
- R5: A one-cycle `rd_en` pulse clears `rx_ready` on the next edge. `rd_en` does not change `rx_data` or `rx_ovr`.
- R6: If a byte completes while `rx_ready` is 1 and no read falls in that cycle, `rx_ovr` becomes 1. In that case the new byte replaces the old one on `rx_data`, and `rx_ready` stays 1.
- R7: `rx_ovr` stays 1 across reads and further bytes until an `ovr_clr` pulse clears it.
- R8: If a byte completes in the same cycle as `rd_en`, `rx_ready` stays 1, `rx_ovr` is not set, and `rx_data` shows the new byte.
- R9: If a byte completes in the same cycle as `ovr_clr` while `rx_ready` is 1 and no read occurs, `rx_ovr` ends up 1: setting wins over clearing.
- R10: Asserting `rst_n` in the middle of a byte discards the partial bits. Bit counting restarts at the first sampled bit after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (host) clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| bit_clk | input | 1 | Line bit clock from the external interface |
| ser_in | input | 1 | NRZ serial data, sampled on rising `bit_clk` |
| rd_en | input | 1 | One-cycle read strobe; clears the ready flag |
| ovr_clr | input | 1 | One-cycle strobe that clears the overrun flag |
| rx_data | output | 8 | Most recently received byte |
| rx_ready | output | 1 | A byte is waiting to be read |
| rx_ovr | output | 1 | Sticky overrun: a byte arrived before the previous one was read |

## Verification
The synchronized byte event can land in the same system cycle as a host read strobe or an overrun clear strobe. Those collisions decide whether a byte is lost silently or reported. The bench generates the bit clock itself, with every edge placed 1 ns after a system edge, so it knows exactly which system cycle carries the byte event. It then drives the read or clear strobe into that same cycle. It judges the result from the ready flag, the overrun flag and the data byte one cycle later, and compares these with a bench model in which a new byte beats a read and setting the overrun flag beats clearing it.

// File: rtl/nrz_rx_pkg.sv
`timescale 1ns/1ps
package nrz_rx_pkg;
  localparam int unsigned DEF_DATA_W      = 8;
  localparam int unsigned DEF_SYNC_STAGES = 2;

  // flags presented to the host
  typedef struct packed {
    logic ready;
    logic ovr;
  } rx_flags_t;
endpackage

// File: rtl/nrz_rx_rst_sync.sv
`timescale 1ns/1ps
// Asynchronous assert, synchronous release of an active-low reset.
module nrz_rx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/nrz_rx_bit_sync.sv
`timescale 1ns/1ps
// Multi-flop synchronizer for a single level signal.
module nrz_rx_bit_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q
);
  logic [STAGES-1:0] stage_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= 1'b0;
          else        stage_q[g] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= 1'b0;
          else        stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/nrz_rx_collect.sv
`timescale 1ns/1ps
// Bit-clock domain: shift register, bit counter, holding register, event toggle.
module nrz_rx_collect #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              bit_clk,
  input  logic              rst_n,
  input  logic              ser_in,
  output logic [DATA_W-1:0] hold_o,
  output logic              tgl_o
);
  localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0]  cnt_q,   cnt_d;
  logic [DATA_W-1:0] shreg_q, shreg_d;
  logic [DATA_W-1:0] hold_q,  hold_d;
  logic              tgl_q,   tgl_d;
  logic              last_bit;

  always_comb begin
    last_bit = (cnt_q == LAST_CNT);
    shreg_d  = {shreg_q[DATA_W-2:0], ser_in};
    cnt_d    = last_bit ? '0 : cnt_q + 1'b1;
    hold_d   = hold_q;
    tgl_d    = tgl_q;
    if (last_bit) begin
      hold_d = shreg_d;
      tgl_d  = ~tgl_q;
    end
  end

  always_ff @(posedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      shreg_q <= '0;
      hold_q  <= '0;
      tgl_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      shreg_q <= shreg_d;
      if (last_bit) hold_q <= hold_d;
      tgl_q   <= tgl_d;
    end
  end

  assign hold_o = hold_q;
  assign tgl_o  = tgl_q;
endmodule

// File: rtl/nrz_rx_host.sv
`timescale 1ns/1ps
// System domain: event recovery, data capture, ready and overrun flags.
module nrz_rx_host
  import nrz_rx_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tgl_async,
  input  logic [DATA_W-1:0] hold_async,
  input  logic              rd_en,
  input  logic              ovr_clr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              rx_ovr,
  output logic              byte_evt
);
  logic              tgl_s;
  logic              tgl_prev_q;
  logic [DATA_W-1:0] data_q, data_d;
  rx_flags_t         flags_q, flags_d;

  nrz_rx_bit_sync #(.STAGES(SYNC_STAGES)) u_tgl_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (tgl_async),
    .q       (tgl_s)
  );

  always_comb begin
    byte_evt = tgl_s ^ tgl_prev_q;
    data_d   = byte_evt ? hold_async : data_q;

    flags_d = flags_q;
    if (byte_evt)   flags_d.ready = 1'b1;
    else if (rd_en) flags_d.ready = 1'b0;

    if (byte_evt && flags_q.ready && !rd_en) flags_d.ovr = 1'b1;
    else if (ovr_clr)                       flags_d.ovr = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgl_prev_q <= 1'b0;
      data_q     <= '0;
      flags_q    <= '0;
    end else begin
      tgl_prev_q <= tgl_s;
      if (byte_evt) data_q <= data_d;
      flags_q    <= flags_d;
    end
  end

  assign rx_data  = data_q;
  assign rx_ready = flags_q.ready;
  assign rx_ovr   = flags_q.ovr;
endmodule

// File: rtl/nrz_rx_chan.sv
`timescale 1ns/1ps
module nrz_rx_chan
  import nrz_rx_pkg::*;
#(
  parameter int unsigned DATA_W      = DEF_DATA_W,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_clk,
  input  logic              ser_in,
  input  logic              rd_en,
  input  logic              ovr_clr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              rx_ovr
);
  logic              bit_rst_n;
  logic              sys_rst_n;
  logic [DATA_W-1:0] hold_w;
  logic              tgl_w;
  logic              byte_evt;

  nrz_rx_rst_sync #(.STAGES(SYNC_STAGES)) u_bit_rst (
    .clk     (bit_clk),
    .arst_n  (rst_n),
    .rst_n_o (bit_rst_n)
  );

  nrz_rx_rst_sync #(.STAGES(SYNC_STAGES)) u_sys_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (sys_rst_n)
  );

  nrz_rx_collect #(.DATA_W(DATA_W)) u_collect (
    .bit_clk (bit_clk),
    .rst_n   (bit_rst_n),
    .ser_in  (ser_in),
    .hold_o  (hold_w),
    .tgl_o   (tgl_w)
  );

  nrz_rx_host #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_host (
    .clk        (clk),
    .rst_n      (sys_rst_n),
    .tgl_async  (tgl_w),
    .hold_async (hold_w),
    .rd_en      (rd_en),
    .ovr_clr    (ovr_clr),
    .rx_data    (rx_data),
    .rx_ready   (rx_ready),
    .rx_ovr     (rx_ovr),
    .byte_evt   (byte_evt)
  );
endmodule

// File: rtl/nrz_rx_chan_chk.sv
`timescale 1ns/1ps
module nrz_rx_chan_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic              ovr_clr,
  input logic              byte_evt,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_ready,
  input logic              rx_ovr
);
  p_reset_r1: assert property (@(posedge clk)
    !rst_n |-> (!rx_ready && !rx_ovr && rx_data == '0));

  p_data_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_evt |=> $stable(rx_data));

  p_ready_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ready) |-> $past(byte_evt));

  p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !byte_evt) |=> !rx_ready);

  p_ovr_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_evt && rx_ready && !rd_en) |=> (rx_ovr && rx_ready));

  p_ovr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ovr && !ovr_clr) |=> rx_ovr);

  p_read_collide_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_evt && rd_en && !ovr_clr) |=> (rx_ready && rx_ovr == $past(rx_ovr)));

  p_clr_collide_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_evt && rx_ready && !rd_en && ovr_clr) |=> rx_ovr);
endmodule

bind nrz_rx_chan nrz_rx_chan_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rd_en    (rd_en),
  .ovr_clr  (ovr_clr),
  .byte_evt (byte_evt),
  .rx_data  (rx_data),
  .rx_ready (rx_ready),
  .rx_ovr   (rx_ovr)
);

// File: tb/nrz_rx_chan_tb.sv
`timescale 1ns/1ps
module nrz_rx_chan_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_clk = 1'b0;
  logic       ser_in = 1'b0;
  logic       rd_en = 1'b0;
  logic       ovr_clr = 1'b0;
  logic [7:0] rx_data;
  logic       rx_ready;
  logic       rx_ovr;

  int checks = 0;
  int errors = 0;

  logic [7:0] exp_data = 8'h00;
  logic       exp_ready = 1'b0;
  logic       exp_ovr = 1'b0;

  always #4 clk = ~clk;

  nrz_rx_chan u_dut (
    .clk(clk), .rst_n(rst_n), .bit_clk(bit_clk), .ser_in(ser_in),
    .rd_en(rd_en), .ovr_clr(ovr_clr),
    .rx_data(rx_data), .rx_ready(rx_ready), .rx_ovr(rx_ovr)
  );

  // ---- reference model ----
  function automatic logic model_ovr(logic rdy, logic ovr, logic rd, logic clr, logic evt);
    if (evt && rdy && !rd) return 1'b1;
    if (clr)               return 1'b0;
    return ovr;
  endfunction

  function automatic logic model_ready(logic rdy, logic rd, logic evt);
    if (evt) return 1'b1;
    if (rd)  return 1'b0;
    return rdy;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_all(input string tag);
    chk({tag, " data"},  {24'h0, rx_data}, {24'h0, exp_data});
    chk({tag, " ready"}, {31'h0, rx_ready}, {31'h0, exp_ready});
    chk({tag, " ovr"},   {31'h0, rx_ovr},   {31'h0, exp_ovr});
  endtask

  // one bit-clock period: 4 system cycles high, 4 low, edges 1 ns after clk
  task automatic bit_pulse(input logic b);
    @(negedge clk) ser_in = b;
    @(posedge clk); #1 bit_clk = 1'b1;
    repeat (4) @(posedge clk);
    #1 bit_clk = 1'b0;
    repeat (3) @(posedge clk);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) bit_pulse(b[i]);
  endtask

  task automatic send_byte(input logic [7:0] b);
    send_bits(b, 8);
    exp_ovr   = model_ovr(exp_ready, exp_ovr, 1'b0, 1'b0, 1'b1);
    exp_ready = 1'b1;
    exp_data  = b;
    @(negedge clk);
  endtask

  // last bit placed so the byte event lands in a known cycle; strobes hit it
  task automatic send_byte_hit(input logic [7:0] b, input logic do_rd, input logic do_clr);
    logic pre_ready;
    pre_ready = exp_ready;
    send_bits(b, 7);
    @(negedge clk) ser_in = b[0];
    @(posedge clk); #1 bit_clk = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    if (!pre_ready) chk("R3 ready still low after two edges", {31'h0, rx_ready}, 32'h0);
    rd_en = do_rd; ovr_clr = do_clr;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0; ovr_clr = 1'b0;
    if (!pre_ready) chk("R3 ready high at third edge", {31'h0, rx_ready}, 32'h1);
    exp_ovr   = model_ovr(exp_ready, exp_ovr, do_rd, do_clr, 1'b1);
    exp_ready = model_ready(exp_ready, do_rd, 1'b1);
    exp_data  = b;
    @(posedge clk); #1 bit_clk = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic host_read();
    @(negedge clk) rd_en = 1'b1;
    @(negedge clk) rd_en = 1'b0;
    exp_ready = model_ready(exp_ready, 1'b1, 1'b0);
  endtask

  task automatic host_clr();
    @(negedge clk) ovr_clr = 1'b1;
    @(negedge clk) ovr_clr = 1'b0;
    exp_ovr = model_ovr(exp_ready, exp_ovr, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    repeat (3) @(negedge clk);
    exp_data = 8'h00; exp_ready = 1'b0; exp_ovr = 1'b0;
    chk_all("R1 during reset");
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    bit_pulse(1'b0);   // two bit-clock edges release the line-side reset
    bit_pulse(1'b0);
    @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired checks=%0d", checks);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rb;
    void'($urandom(32'h1f2e3d4c));
    do_reset();
    chk_all("R1 after release");

    // R2: bit order and alignment
    send_byte(8'h80); chk_all("R2 msb first 80");
    host_read();      chk_all("R5 read clears");
    send_byte(8'h01); chk_all("R2 lsb last 01");
    host_read();
    // R5: read with nothing pending changes nothing
    host_read();      chk_all("R5 idle read no effect");

    // R3 timing with ready low, no strobe
    send_byte_hit(8'hC3, 1'b0, 1'b0); chk_all("R3 byte C3");

    // R6: second byte without read
    send_byte(8'h5A); chk_all("R6 overrun set, newest kept");
    // R7: sticky across read and further bytes
    host_read();      chk_all("R7 ovr survives read");
    send_byte(8'h11); chk_all("R7 ovr survives byte");
    host_clr();       chk_all("R7 clear strobe");

    // R8: read collides with a new byte while ready is set
    send_byte_hit(8'h3C, 1'b1, 1'b0); chk_all("R8 read collision");
    host_read();

    // R9: clear collides with an overrun-setting byte
    send_byte(8'h21); send_byte(8'h22);  // ready=1 ovr=1
    send_byte_hit(8'h77, 1'b0, 1'b1); chk_all("R9 set beats clear");
    host_read(); host_clr(); chk_all("R9 cleanup");

    // R10: reset mid-byte discards partial bits
    send_bits(8'hFF, 3);
    do_reset();
    send_byte(8'hA5); chk_all("R10 realigned after reset");
    host_read();

    // random traffic (R2 R4 R5 R6 R7)
    for (int n = 0; n < 80; n++) begin
      if ($urandom % 3 == 0) host_read();
      if ($urandom % 5 == 0) host_clr();
      rb = 8'($urandom);
      send_byte(rb);
      chk_all("R4 random byte");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule